// File: doc/BRIEF.md
# Address Security Attribution with Region Aliasing

This block watches a 32-bit system address and, in the same cycle, reports its security attributes: the 4-bit region ID, whether the address is non-secure, whether it is non-secure-callable, and whether it is exempt from attribution. The attributes are plain functions of the upper address bits. The callable attribute is also gated by a 2-bit configuration register that the security controller writes.

Alongside the attributes, the block gives the physical address after aliasing. Three odd regions mirror the even region just below them. A small set of 4 KB control pages inside region 5 keep their own address and raise a select line instead, so those control devices win over the mirror.

Top module: `sec_attr_alias`

## Requirements
- R1: `region_o` equals address bits [31:28] in the same cycle, with no register in the path.
- R2: `ns_o` is 1 when address bit 28 is 0, and 0 when it is 1.
- R3: `nsc_o` is 1 for region 1 only when config bit 0 is 1, and for region 3 only when config bit 1 is 1. It is 0 for every other region.
- R4: `exempt_o` is 1 exactly when (address & 0xEFF00000) == 0xE0000000. So 0xE00FFFFF and 0xF00FFFFF are exempt, and 0xE0100000, 0xF0100000 and 0xDFFFFFFF are not.
- R5: Reset (asynchronous, active low) clears the config register, so `cfg_rdata_o` reads 0 and `nsc_o` is 0 for every region.
- R6: On a clock edge where `cfg_we_i` is 1, `cfg_wdata_i[1:0]` is loaded. The new value shows on `cfg_rdata_o` and `nsc_o` after that edge and not before. Bits [31:2] of the write data are ignored, and `cfg_rdata_o[31:2]` always reads 0. Without a write, the register holds its value.
- R7: Addresses in regions 1, 3 and 5 fold to regions 0, 2 and 4: bit 28 is cleared and every other bit is kept. Addresses in all other regions pass through unchanged.
- R8: Each of the 4 KB control pages 0x50080000, 0x50081000, 0x50021000 and 0x5002E000 drives `ctrl_sel_o` to 1 and passes its address through unfolded.
- R9: `NUM_MPC_PAGES` further control pages start at 0x50083000 and step by 4 KB; the default is 1. The page just past the last one (0x50084000 by default) folds normally. So does the gap page 0x50082000.
- R10: `ctrl_sel_o` is 0 for every address outside region 5. This includes region 4 at the same offsets, such as 0x40080000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Address under test |
| cfg_we_i | input | 1 | Config write strobe, one cycle |
| cfg_wdata_i | input | 32 | Config write data; only [1:0] is used |
| cfg_rdata_o | output | 32 | Config readback, zero-extended |
| region_o | output | 4 | Region ID |
| ns_o | output | 1 | Non-secure attribute |
| nsc_o | output | 1 | Non-secure-callable attribute |
| exempt_o | output | 1 | Exempt from attribution |
| phys_addr_o | output | 32 | Address after alias folding |
| ctrl_sel_o | output | 1 | Control-page select |

## Verification
Every attribute, the folded address and the control select are combinational from the address. The bench changes the address on a falling edge and samples 1 ns later, in the same cycle. A config write takes one rising edge. The bench drives the strobe at a falling edge and first checks that the readback and `nsc_o` still show the old value 1 ns later. It then checks them again at the next falling edge, after the loading edge has passed. The region/config sweep does each write this way before it walks the 16 regions.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int ADDR_W    = 32;
  localparam int REGION_W  = 4;
  localparam int CFG_W     = 2;
  localparam int PAGE_LSB  = 12;
  localparam int PAGE_W    = ADDR_W - PAGE_LSB;
  localparam int HI_LSB    = 20;
  localparam int HI_W      = ADDR_W - HI_LSB;

  localparam logic [HI_W-1:0] EXEMPT_MASK  = 12'hEFF;
  localparam logic [HI_W-1:0] EXEMPT_MATCH = 12'hE00;

  // regions whose addresses mirror the even region below
  localparam logic [15:0] FOLD_REGIONS = 16'b0000_0000_0010_1010;

  localparam int FIXED_WIN_N = 4;
  localparam logic [PAGE_W-1:0] FIXED_PAGES [FIXED_WIN_N] = '{
    20'h50080, 20'h50081, 20'h50021, 20'h5002E
  };
  localparam logic [PAGE_W-1:0] MPC_BASE_PAGE = 20'h50083;

  typedef struct packed {
    logic [REGION_W-1:0] region;
    logic                ns;
    logic                nsc;
    logic                exempt;
  } attr_t;
endpackage

// File: rtl/sau_cfg_reg.sv
module sau_cfg_reg
  import sau_pkg::*;
#(
  parameter int IN_W = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IN_W-1:0]  wdata_i,
  output logic [CFG_W-1:0] q_o
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[IN_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i[CFG_W-1:0];
  end
endmodule

// File: rtl/sau_attr_decode.sv
module sau_attr_decode
  import sau_pkg::*;
(
  input  logic [HI_W-1:0]  hi_i,
  input  logic [CFG_W-1:0] cfg_i,
  output attr_t            attr_o
);
  logic [REGION_W-1:0] region;
  assign region = hi_i[HI_W-1 -: REGION_W];

  always_comb begin
    attr_o.region = region;
    attr_o.ns     = ~region[0];
    attr_o.exempt = (hi_i & EXEMPT_MASK) == EXEMPT_MATCH;
    unique case (region)
      4'h1:    attr_o.nsc = cfg_i[0];
      4'h3:    attr_o.nsc = cfg_i[1];
      default: attr_o.nsc = 1'b0;
    endcase
  end
endmodule

// File: rtl/sau_window_decode.sv
module sau_window_decode
  import sau_pkg::*;
#(
  parameter int NUM_MPC_PAGES = 1
) (
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);
  localparam int NW = FIXED_WIN_N + NUM_MPC_PAGES;
  logic [NW-1:0] hit_vec;

  for (genvar g = 0; g < FIXED_WIN_N; g++) begin : g_fixed
    assign hit_vec[g] = page_i == FIXED_PAGES[g];
  end
  for (genvar m = 0; m < NUM_MPC_PAGES; m++) begin : g_mpc
    assign hit_vec[FIXED_WIN_N+m] = page_i == (MPC_BASE_PAGE + PAGE_W'(m));
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/sau_alias_fold.sv
module sau_alias_fold
  import sau_pkg::*;
#(
  parameter logic [15:0] FOLD_MASK = FOLD_REGIONS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctrl_hit_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic fold;
  assign fold = FOLD_MASK[addr_i[ADDR_W-1 -: REGION_W]] & ~ctrl_hit_i;

  always_comb begin
    phys_o = addr_i;
    if (fold) phys_o[ADDR_W-REGION_W] = 1'b0;
  end
endmodule

// File: rtl/sec_attr_alias.sv
module sec_attr_alias
  import sau_pkg::*;
#(
  parameter int NUM_MPC_PAGES = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic [3:0]  region_o,
  output logic        ns_o,
  output logic        nsc_o,
  output logic        exempt_o,
  output logic [31:0] phys_addr_o,
  output logic        ctrl_sel_o
);
  logic [CFG_W-1:0] cfg_q;
  attr_t            attr;
  logic             ctrl_hit;

  sau_cfg_reg #(.IN_W(ADDR_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (cfg_q)
  );

  sau_attr_decode u_attr (
    .hi_i   (addr_i[ADDR_W-1:HI_LSB]),
    .cfg_i  (cfg_q),
    .attr_o (attr)
  );

  sau_window_decode #(.NUM_MPC_PAGES(NUM_MPC_PAGES)) u_win (
    .page_i (addr_i[ADDR_W-1:PAGE_LSB]),
    .hit_o  (ctrl_hit)
  );

  sau_alias_fold u_fold (
    .addr_i     (addr_i),
    .ctrl_hit_i (ctrl_hit),
    .phys_o     (phys_addr_o)
  );

  assign cfg_rdata_o = {{(ADDR_W-CFG_W){1'b0}}, cfg_q};
  assign region_o    = attr.region;
  assign ns_o        = attr.ns;
  assign nsc_o       = attr.nsc;
  assign exempt_o    = attr.exempt;
  assign ctrl_sel_o  = ctrl_hit;
endmodule

// File: rtl/sau_checker.sv
module sau_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] addr_i,
  input logic        cfg_we_i,
  input logic [1:0]  cfg_wdata_i,
  input logic [31:0] cfg_rdata_o,
  input logic [3:0]  region_o,
  input logic        ns_o,
  input logic        nsc_o,
  input logic        exempt_o,
  input logic [31:0] phys_addr_o,
  input logic        ctrl_sel_o
);
  // R1 / R7: folding only touches bit 28, region ID agrees with the mirror
  a_r1_region_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[31:29] == region_o[3:1]);
  a_r7_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[27:0] == addr_i[27:0]);
  a_r7_fold_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_sel_o && !ns_o && region_o < 4'd6) |-> phys_addr_o[31:28] == region_o - 4'd1);
  a_r7_pass_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o >= 4'd6) |-> phys_addr_o == addr_i);
  // R2 / R3
  a_r3_nsc_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nsc_o |-> (!ns_o && (region_o == 4'd1 || region_o == 4'd3)));
  a_r3_nsc_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nsc_o |-> cfg_rdata_o[region_o[1]]);
  // R4
  a_r4_exempt_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exempt_o |-> (region_o[3:1] == 3'b111 && addr_i[27:20] == 8'h00));
  // R6
  a_r6_write_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == {30'b0, $past(cfg_wdata_i)});
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[31:2] == 30'b0);
  // R8 / R10
  a_r8_ctrl_unfolded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_sel_o |-> phys_addr_o == addr_i);
  a_r10_ctrl_region5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_sel_o |-> region_o == 4'd5);
endmodule

bind sec_attr_alias sau_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i[1:0]),
  .cfg_rdata_o (cfg_rdata_o),
  .region_o    (region_o),
  .ns_o        (ns_o),
  .nsc_o       (nsc_o),
  .exempt_o    (exempt_o),
  .phys_addr_o (phys_addr_o),
  .ctrl_sel_o  (ctrl_sel_o)
);

// File: tb/sim_sec_attr_alias.sv
module sim_sec_attr_alias;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  region;
  logic        ns, nsc, exempt, ctrl_sel;
  logic [31:0] phys;
  int          n_tests = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  sec_attr_alias u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .region_o(region),
    .ns_o(ns), .nsc_o(nsc), .exempt_o(exempt), .phys_addr_o(phys),
    .ctrl_sel_o(ctrl_sel)
  );

  // {addr, expected phys, expected ctrl_sel}  (R7, R8, R9, R10)
  localparam int NV = 15;
  localparam logic [64:0] VEC [NV] = '{
    {32'h1234_5678, 32'h0234_5678, 1'b0},
    {32'h3000_0010, 32'h2000_0010, 1'b0},
    {32'h5000_1000, 32'h4000_1000, 1'b0},
    {32'h5008_0000, 32'h5008_0000, 1'b1},
    {32'h5008_0FFC, 32'h5008_0FFC, 1'b1},
    {32'h5008_1004, 32'h5008_1004, 1'b1},
    {32'h5008_3000, 32'h5008_3000, 1'b1},
    {32'h5008_4000, 32'h4008_4000, 1'b0},
    {32'h5008_2000, 32'h4008_2000, 1'b0},
    {32'h5002_1010, 32'h5002_1010, 1'b1},
    {32'h5002_E000, 32'h5002_E000, 1'b1},
    {32'h5002_F000, 32'h4002_F000, 1'b0},
    {32'h4008_0000, 32'h4008_0000, 1'b0},
    {32'h7000_0000, 32'h7000_0000, 1'b0},
    {32'h0000_0004, 32'h0000_0004, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  // R6: old value visible with strobe high, new value after the edge
  task automatic write_cfg(input logic [31:0] v, input logic [31:0] old_v);
    @(negedge clk);
    we = 1'b1;
    wdata = v;
    #1;
    chk("R6 pre-edge readback", rdata, old_v);
    @(negedge clk);
    we = 1'b0;
    wdata = 32'hDEAD_BEEF;
    #1;
    chk("R6 post-edge readback", rdata, {30'b0, v[1:0]});
  endtask

  function automatic logic ref_nsc(input logic [3:0] r, input logic [1:0] c);
    return (r == 4'd1 && c[0]) || (r == 4'd3 && c[1]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R5: reset state
    addr = 32'h1000_0000;
    #3;
    chk("R5 rdata in reset", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R5 rdata after reset", rdata, 32'h0);
    chk("R5 nsc region1 after reset", {31'b0, nsc}, 32'h0);
    set_addr(32'h3000_0000);
    chk("R5 nsc region3 after reset", {31'b0, nsc}, 32'h0);

    // R7..R10 table
    for (int i = 0; i < NV; i++) begin
      set_addr(VEC[i][64:33]);
      chk("R7/R8/R9 phys", phys, VEC[i][32:1]);
      chk("R8/R9/R10 ctrl_sel", {31'b0, ctrl_sel}, {31'b0, VEC[i][0]});
    end

    // R1, R2, R3 sweep over all regions and config values
    for (int c = 0; c < 4; c++) begin
      write_cfg(32'(c), (c == 0) ? 32'h0 : 32'(c - 1));
      for (int r = 0; r < 16; r++) begin
        set_addr({4'(r), 28'h0123456});
        chk("R1 region", {28'b0, region}, 32'(r));
        chk("R2 ns", {31'b0, ns}, {31'b0, ~r[0]});
        chk("R3 nsc", {31'b0, nsc}, {31'b0, ref_nsc(4'(r), 2'(c))});
      end
    end

    // R6: upper write bits ignored
    write_cfg(32'hFFFF_FFFE, 32'h3);
    set_addr(32'h3000_0000);
    chk("R6 nsc region3 after masked write", {31'b0, nsc}, 32'h1);
    set_addr(32'h1000_0000);
    chk("R6 nsc region1 after masked write", {31'b0, nsc}, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 hold without strobe", rdata, 32'h2);

    // R4 exempt boundaries
    set_addr(32'hE000_0000); chk("R4 exempt E0000000", {31'b0, exempt}, 32'h1);
    set_addr(32'hE00F_FFFF); chk("R4 exempt E00FFFFF", {31'b0, exempt}, 32'h1);
    set_addr(32'hE010_0000); chk("R4 exempt E0100000", {31'b0, exempt}, 32'h0);
    set_addr(32'hF00F_FFFF); chk("R4 exempt F00FFFFF", {31'b0, exempt}, 32'h1);
    set_addr(32'hF010_0000); chk("R4 exempt F0100000", {31'b0, exempt}, 32'h0);
    set_addr(32'hDFFF_FFFF); chk("R4 exempt DFFFFFFF", {31'b0, exempt}, 32'h0);
    set_addr(32'hF000_0000); chk("R7 region F passes", phys, 32'hF000_0000);

    // R5: reset again clears a nonzero config
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R5 async clear", rdata, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule